// File: doc/BRIEF.md
# Transmit Address Overlay

This block sits on the sending side of a chip-to-chip memory window. A local master issues a 32-bit bus address that falls inside a 256 MB outbound window, together with its 4-bit privilege index and a security flag. The block turns this into the 32-bit address word that goes into the outbound packet. No separate sideband fields carry the control information. Instead, the block keeps a configurable number of low address bits and then overwrites selected upper bits with the privilege index and, if enabled, the security flag.

One configuration register sets the control fields: the width of the pass-through mask, the position of the privilege index, and the position of the security flag. Software writes this register once, before traffic starts.

A request that falls outside the window is not translated. It returns a zero address word with an error flag. Every result appears on a registered output one cycle after the request is presented.

Top module: `tx_addr_overlay`

## Requirements
- R1: A request whose address bits [31:28] equal 0x4 is inside the window. Any other request produces `out_addr_err` = 1 and `out_addr` = 0 in its result cycle. An in-window request produces `out_addr_err` = 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. `out_addr` and `out_addr_err` belong to that request. `out_valid` is low after reset and after a cycle without a request.
- R3: Mask field value m (0 to 11) passes address bits [m+16:0] unchanged. Field values 12 to 15 act as 11. Bits above the mask that no overlay writes are 0.
- R4: Privilege position field value p writes the 4-bit privilege index into bits [p+19:p+16], replacing whatever the mask let through. Field values 13 to 15 act as 12.
- R5: Security position field value 0 overlays no security flag. A value s from 1 to 15 writes the flag into bit s+16. Where that bit also holds a privilege bit, the security flag wins.
- R6: Address bits [15:0] of an in-window request always reach the output unchanged.
- R7: The control register sits at byte offset 0x1C. Its layout is: mask field in bits [3:0], privilege position in bits [11:8], security position in bits [19:16]. All other bits read 0. Reads return the last written fields. A write to any other offset changes nothing, and reads at other offsets return 0. A write takes effect for requests from the following cycle.
- R8: After reset the fields hold mask 11, privilege position 12 and security position 0, so the register reads 0x0000_0C0B. With these values, a request from master 5 to 0x4567_89A0 yields 0x5567_89A0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational from `cfg_addr`) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Local bus address of the request |
| req_priv | input | 4 | Privilege index of the requesting master |
| req_secure | input | 1 | Security flag of the request |
| out_valid | output | 1 | Result present |
| out_addr | output | 32 | Packet address word |
| out_addr_err | output | 1 | Request was outside the window |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 4-bit window tag of 0x4, the overlay region starting at bit 16, and the security overlay variant enabled. All control fields are 4 bits wide. Random register writes therefore reach every field code, including the clamped mask values 12 to 15 and the clamped privilege positions 13 to 15. They also reach every security position up to bit 31, including overlaps with the privilege bits. Directed cases cover the reset example, out-of-window addresses, writes at a wrong offset and a narrow 17-bit mask.

// File: rtl/txo_pkg.sv
package txo_pkg;
   localparam int TXO_FLD_W = 4;

   typedef struct packed {
      logic [TXO_FLD_W-1:0] mask_sel;
      logic [TXO_FLD_W-1:0] priv_pos;
      logic [TXO_FLD_W-1:0] sec_pos;
   } txo_cfg_t;
endpackage

// File: rtl/txo_cfg_regs.sv
module txo_cfg_regs
   import txo_pkg::*;
#(
   parameter int                CFG_AW   = 8,
   parameter int                CFG_DW   = 32,
   parameter logic [CFG_AW-1:0] REG_OFF  = 'h1C,
   parameter int                MASK_LSB = 0,
   parameter int                PRIV_LSB = 8,
   parameter int                SEC_LSB  = 16,
   parameter int                RST_MASK = 11,
   parameter int                RST_PRIV = 12,
   parameter int                RST_SEC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   output txo_cfg_t          cfg_o
);
   if (CFG_DW < SEC_LSB + TXO_FLD_W || CFG_DW < PRIV_LSB + TXO_FLD_W ||
       CFG_DW < MASK_LSB + TXO_FLD_W) begin : g_bad_layout
      $error("txo_cfg_regs: register too narrow for field layout");
   end

   logic hit;
   logic unused_wdata;

   assign hit          = (cfg_addr == REG_OFF);
   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o.mask_sel <= TXO_FLD_W'(RST_MASK);
         cfg_o.priv_pos <= TXO_FLD_W'(RST_PRIV);
         cfg_o.sec_pos  <= TXO_FLD_W'(RST_SEC);
      end else if (cfg_we && hit) begin
         cfg_o.mask_sel <= cfg_wdata[MASK_LSB +: TXO_FLD_W];
         cfg_o.priv_pos <= cfg_wdata[PRIV_LSB +: TXO_FLD_W];
         cfg_o.sec_pos  <= cfg_wdata[SEC_LSB  +: TXO_FLD_W];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (hit) begin
         cfg_rdata[MASK_LSB +: TXO_FLD_W] = cfg_o.mask_sel;
         cfg_rdata[PRIV_LSB +: TXO_FLD_W] = cfg_o.priv_pos;
         cfg_rdata[SEC_LSB  +: TXO_FLD_W] = cfg_o.sec_pos;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && hit |=> cfg_o.priv_pos == $past(cfg_wdata[PRIV_LSB +: TXO_FLD_W])); // R7
   AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && hit) |=> $stable(cfg_o)); // R7
endmodule

// File: rtl/txo_mask_gen.sv
module txo_mask_gen
   import txo_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OVL_BASE     = 16,
   parameter int MASK_SEL_MAX = 11
) (
   input  logic [TXO_FLD_W-1:0] mask_sel,
   output logic [ADDR_W-1:0]    mask_o
);
   int lim;

   always_comb begin
      if (int'(mask_sel) > MASK_SEL_MAX) lim = OVL_BASE + MASK_SEL_MAX;
      else                                lim = OVL_BASE + int'(mask_sel);
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      localparam int I = i;
      if (I < OVL_BASE) begin : g_fixed
         assign mask_o[i] = 1'b1;
      end else begin : g_sel
         assign mask_o[i] = (I <= lim);
      end
   end
endmodule

// File: rtl/txo_overlay.sv
module txo_overlay
   import txo_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int PRIV_W       = 4,
   parameter int OVL_BASE     = 16,
   parameter int PRIV_POS_MAX = 12,
   parameter bit SEC_EN       = 1'b1
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]    mask,
   input  logic [PRIV_W-1:0]    priv,
   input  logic                 secure,
   input  logic [TXO_FLD_W-1:0] priv_pos,
   input  logic [TXO_FLD_W-1:0] sec_pos,
   output logic [ADDR_W-1:0]    ovl_addr
);
   localparam int IDX_W = $clog2(ADDR_W);

   int                pp;
   logic [IDX_W-1:0]  pidx;
   logic [ADDR_W-1:0] with_priv;

   always_comb begin
      if (int'(priv_pos) > PRIV_POS_MAX) pp = PRIV_POS_MAX;
      else                                pp = int'(priv_pos);
      with_priv = addr & mask;
      pidx      = '0;
      for (int k = 0; k < PRIV_W; k++) begin
         pidx            = IDX_W'(OVL_BASE + pp + k);
         with_priv[pidx] = priv[k];
      end
   end

   if (SEC_EN) begin : g_sec
      logic [IDX_W-1:0] sidx;
      assign sidx = IDX_W'(OVL_BASE + int'(sec_pos));
      always_comb begin
         ovl_addr = with_priv;
         if (sec_pos != '0) ovl_addr[sidx] = secure;
      end
   end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = secure ^ (^sec_pos);
      assign ovl_addr   = with_priv;
   end
endmodule

// File: rtl/tx_addr_overlay.sv
module tx_addr_overlay
   import txo_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int TAG_W    = 4,
   parameter int TAG_VAL  = 4,
   parameter int PRIV_W   = 4,
   parameter int OVL_BASE = 16,
   parameter bit SEC_EN   = 1'b1,
   parameter int CFG_AW   = 8,
   parameter int CFG_DW   = 32,
   parameter logic [CFG_AW-1:0] REG_OFF = 'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [CFG_DW-1:0] cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PRIV_W-1:0] req_priv,
   input  logic              req_secure,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_addr_err
);
   localparam int MASK_SEL_MAX = ADDR_W - TAG_W - OVL_BASE - 1;
   localparam int PRIV_POS_MAX = ADDR_W - PRIV_W - OVL_BASE;

   if (MASK_SEL_MAX < 0 || MASK_SEL_MAX >= (1 << TXO_FLD_W)) begin : g_bad_mask
      $error("tx_addr_overlay: mask range does not fit field");
   end
   if (PRIV_POS_MAX < 0) begin : g_bad_priv
      $error("tx_addr_overlay: privilege index does not fit above overlay base");
   end
   if (SEC_EN && (OVL_BASE + (1 << TXO_FLD_W) - 1 > ADDR_W - 1)) begin : g_bad_sec
      $error("tx_addr_overlay: security position can exceed address width");
   end

   txo_cfg_t          cfg;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] ovl;
   logic              win_ok;

   txo_cfg_regs #(
      .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .REG_OFF(REG_OFF),
      .RST_MASK(MASK_SEL_MAX), .RST_PRIV(PRIV_POS_MAX), .RST_SEC(0)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_o(cfg)
   );

   txo_mask_gen #(
      .ADDR_W(ADDR_W), .OVL_BASE(OVL_BASE), .MASK_SEL_MAX(MASK_SEL_MAX)
   ) u_mask (
      .mask_sel(cfg.mask_sel), .mask_o(mask)
   );

   txo_overlay #(
      .ADDR_W(ADDR_W), .PRIV_W(PRIV_W), .OVL_BASE(OVL_BASE),
      .PRIV_POS_MAX(PRIV_POS_MAX), .SEC_EN(SEC_EN)
   ) u_ovl (
      .addr(req_addr), .mask(mask), .priv(req_priv), .secure(req_secure),
      .priv_pos(cfg.priv_pos), .sec_pos(cfg.sec_pos), .ovl_addr(ovl)
   );

   assign win_ok = (req_addr[ADDR_W-1 -: TAG_W] == TAG_W'(TAG_VAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_addr     <= '0;
         out_addr_err <= 1'b0;
      end else begin
         out_valid    <= req_valid;
         out_addr_err <= req_valid && !win_ok;
         if (req_valid) out_addr <= win_ok ? ovl : '0;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid); // R2
   AST_OUTSIDE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !win_ok |=> out_addr_err && out_addr == '0); // R1
   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && win_ok |=> out_addr[OVL_BASE-1:0] == $past(req_addr[OVL_BASE-1:0])); // R6
   AST_PRIV_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && win_ok && cfg.priv_pos == TXO_FLD_W'(PRIV_POS_MAX) && cfg.sec_pos == '0
      |=> out_addr[ADDR_W-1 -: PRIV_W] == $past(req_priv)); // R4
endmodule

// File: tb/tb_tx_addr_overlay.sv
`timescale 1ns/1ps
module tb_tx_addr_overlay;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h1C;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_priv = '0;
   logic        req_secure = 1'b0;
   logic        out_valid;
   logic [31:0] out_addr;
   logic        out_addr_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] m_f = 4'd11, p_f = 4'd12, s_f = 4'd0;

   always #4 clk = ~clk;

   tx_addr_overlay dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_priv(req_priv), .req_secure(req_secure),
      .out_valid(out_valid), .out_addr(out_addr), .out_addr_err(out_addr_err)
   );

   function automatic logic [31:0] model(logic [31:0] a, logic [3:0] pv, logic sc,
                                         logic [3:0] m, logic [3:0] p, logic [3:0] s);
      logic [63:0] mk;
      logic [31:0] r;
      int mm, pq;
      if (a[31:28] != 4'h4) return 32'h0;
      mm = (m > 4'd11) ? 11 : int'(m);
      pq = (p > 4'd12) ? 12 : int'(p);
      mk = (64'h1 << (mm + 17)) - 64'h1;
      r  = a & mk[31:0];
      r  = (r & ~(32'hF << (pq + 16))) | ({28'h0, pv} << (pq + 16));
      if (s != 4'd0) r[int'(s) + 16] = sc;
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic write_cfg(logic [7:0] off, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = 8'h1C;
      if (off == 8'h1C) begin
         m_f = d[3:0]; p_f = d[11:8]; s_f = d[19:16];
      end
      #1 check("R7 readback", cfg_rdata, {12'h0, s_f, 4'h0, p_f, 4'h0, m_f});
   endtask

   task automatic apply(logic v, logic [31:0] a, logic [3:0] pv, logic sc, string req);
      req_valid = v; req_addr = a; req_priv = pv; req_secure = sc;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 valid", {31'h0, out_valid}, {31'h0, v});
      if (v) begin
         check("R1 err flag", {31'h0, out_addr_err}, {31'h0, a[31:28] != 4'h4});
         check(req, out_addr, model(a, pv, sc, m_f, p_f, s_f));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check("R2 reset valid", {31'h0, out_valid}, 32'h0);
      check("R8 reset reg", cfg_rdata, 32'h0000_0C0B);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset example
      apply(1'b1, 32'h4567_89A0, 4'd5, 1'b0, "R8 example");
      check("R8 example literal", out_addr, 32'h5567_89A0);
      // R1: outside window
      apply(1'b1, 32'h8000_0000, 4'd3, 1'b1, "R1 outside");
      check("R1 outside zero", out_addr, 32'h0);
      apply(1'b1, 32'h3FFF_FFFF, 4'd1, 1'b0, "R1 below window");
      // R2: idle
      apply(1'b0, 32'h4000_0000, 4'd0, 1'b0, "R2 idle");
      // R7: stray write ignored
      write_cfg(8'h20, 32'h000F_0F0F);
      cfg_addr = 8'h20; #1 check("R7 other offset reads 0", cfg_rdata, 32'h0);
      cfg_addr = 8'h1C; #1 check("R7 stray write ignored", cfg_rdata, 32'h0000_0C0B);
      @(negedge clk);
      // R3: clamp
      write_cfg(8'h1C, 32'hFFF0_0C0F);
      apply(1'b1, 32'h4ABC_DEF1, 4'd9, 1'b0, "R3 mask clamp");
      check("R3 clamp literal", out_addr, 32'h9ABC_DEF1);
      // R4: narrow mask, privilege overwrites bit 16
      write_cfg(8'h1C, 32'h0000_0000);
      apply(1'b1, 32'h4FFF_FFFF, 4'hA, 1'b1, "R4 overwrite");
      check("R4 overwrite literal", out_addr, 32'h000A_FFFF);
      // R5: security wins at bit 28
      write_cfg(8'h1C, 32'h000C_0C0B);
      apply(1'b1, 32'h4000_0000, 4'h0, 1'b1, "R5 overlap");
      check("R5 overlap literal", out_addr, 32'h1000_0000);
      // R4: position clamp
      write_cfg(8'h1C, 32'h0000_0F05);
      apply(1'b1, 32'h4123_4567, 4'h6, 1'b0, "R4 position clamp");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a;
         if (i % 64 == 0) write_cfg(8'h1C, $urandom);
         a = $urandom;
         if ($urandom % 5 != 0) a[31:28] = 4'h4;
         apply(($urandom % 10) != 0, a, 4'($urandom), 1'($urandom), "R4 random translate");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule